// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Flag Modes

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Write pointers and read pointers are Gray coded and cross into the opposite domain through two-flop synchronizers. Status flags are then computed from a local pointer and a synchronized pointer, so a flag reacts late to events in the far domain, but never early. All control inputs and all flags are active low.

A static mode input selects the read-side behaviour. In standard mode a read request moves the next word into the output register, and the two main flags report empty and full. In fall-through mode the oldest word is loaded into the output register without any request. The read flag then reports that a word is ready and the write flag reports that room is available. Because the output register holds one word, capacity in this mode is the memory depth plus one.

Almost-empty, almost-full and half-full flags compare a level against the static offset inputs. That level counts words held in the memory array, not the fall-through output register. Separate chip selects gate writes and reads. The high-impedance state of the data output is represented by a `dout_valid` signal, with `dout` forced to zero whenever it is not driven.

Top module: `dcfifo_flags`

## Requirements
- R1: When `mrst_n` is held low, the pointers clear and the flags take the empty state of the selected mode. In standard mode that is `rflag_n`=0, `wflag_n`=1; in fall-through mode it is `rflag_n`=1, `wflag_n`=0. In both modes `ae_n`=0, `af_n`=1 and `hf_n`=1.
- R2: In standard mode, `rflag_n` (0 = empty) rises on the 2nd `rclk` rising edge after the `wclk` edge that wrote into an empty FIFO, or on the 3rd edge when the two clocks are close in phase.
- R3: In standard mode, `wflag_n` (0 = full) is 0 once DEPTH words are stored. Writes made while the flag is 0 are dropped. `wflag_n` returns to 1 on the 2nd or 3rd `wclk` edge after a read frees a location.
- R4: In standard mode, a read (`rd_en_n`=0, `rd_cs_n`=0, not empty) at an `rclk` edge places the oldest word on `dout` at that edge. The read that takes the last word drives `rflag_n` to 0 at the same edge. A read while empty leaves `dout` unchanged.
- R5: In fall-through mode, the first word written reaches `dout` with no read request. `rflag_n` (0 = word ready) falls on the 3rd or 4th `rclk` edge after the write.
- R6: In fall-through mode, DEPTH+1 words can be stored. `wflag_n` (0 = room available) is 1 when no more can be accepted.
- R7: `ae_n` is 0 while the read-side level is at or below `empty_off`. It rises on the 2nd or 3rd `rclk` edge after the write that raises the level above `empty_off`.
- R8: `af_n` is 0 when the write-side level is at least DEPTH minus `full_off`. `hf_n` is 0 when that level exceeds DEPTH/2.
- R9: `wr_cs_n`=1 makes a write request have no effect. `rd_cs_n`=1 makes a read request have no effect and sets `dout_valid` to 0. `out_en_n`=1 sets `dout_valid` to 0.
- R10: In fall-through mode, a ready word is held on `dout` until a read (`rd_en_n`=0, `rd_cs_n`=0) takes it. A read that takes the last stored word drives `rflag_n` to 1 at that edge.
- R11: Under concurrent traffic in either mode, every accepted word is delivered once, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| fwft_mode | input | 1 | Static mode select: 0 standard, 1 fall-through |
| empty_off | input | AW+1 | Almost-empty offset |
| full_off | input | AW+1 | Almost-full offset |
| wr_en_n | input | 1 | Write enable, active low |
| wr_cs_n | input | 1 | Write chip select, active low |
| din | input | DW | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rd_cs_n | input | 1 | Read chip select, active low |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | DW | Read data, zero when not driven |
| dout_valid | output | 1 | Data output is driven |
| rflag_n | output | 1 | Empty (standard) or word ready (fall-through) |
| wflag_n | output | 1 | Full (standard) or room available (fall-through) |
| ae_n | output | 1 | Almost empty, active low |
| af_n | output | 1 | Almost full, active low |
| hf_n | output | 1 | Half full, active low |

## Verification
The hardest states to reach are the flag boundaries, because each flag sees the far domain only through a synchronizer. The bench therefore fills the FIFO one word at a time with reads stopped, and lets both synchronizers settle before sampling `ae_n`, `hf_n`, `af_n` and `wflag_n` at every threshold level. Flag latencies are measured as counts of edges in the observing clock between the causing event and the flag change, and either allowed count is accepted. The two clock periods are chosen so that their rising edges never coincide.

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          fwft_mode,
  input  logic [AW:0]   empty_off,
  input  logic [AW:0]   full_off,
  input  logic          wr_en_n,
  input  logic          wr_cs_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  input  logic          rd_cs_n,
  input  logic          out_en_n,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          rflag_n,
  output logic          wflag_n,
  output logic          ae_n,
  output logic          af_n,
  output logic          hf_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEP = PW'(DEPTH);
  localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray, rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] wnext, rnext, wlevel, rlevel;
  logic          full, mem_empty, wr_go, rd_req, pop, ov;
  logic [DW-1:0] dq;

  assign wnext     = wbin + 1'b1;
  assign rnext     = rbin + 1'b1;
  assign wlevel    = wbin - g2b(rg_s2);
  assign rlevel    = g2b(wg_s2) - rbin;
  assign full      = wlevel[AW];
  assign mem_empty = (rlevel == '0);
  assign wr_go     = !wr_en_n && !wr_cs_n && !full;
  assign rd_req    = !rd_en_n && !rd_cs_n;
  assign pop       = fwft_mode ? (!mem_empty && (!ov || rd_req)) : (rd_req && !mem_empty);

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      ov    <= 1'b0;
      dq    <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (pop) begin
        dq    <= mem[rbin[AW-1:0]];
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (fwft_mode) begin
        if (pop) ov <= 1'b1;
        else if (rd_req) ov <= 1'b0;
      end
    end
  end

  assign rflag_n    = fwft_mode ? !ov : !mem_empty;
  assign wflag_n    = fwft_mode ? full : !full;
  assign ae_n       = !(rlevel <= empty_off);
  assign af_n       = !(wlevel >= DEP - full_off);
  assign hf_n       = !(wlevel > HALF);
  assign dout_valid = !rd_cs_n && !out_en_n;
  assign dout       = dout_valid ? dq : '0;
endmodule

module dcfifo_flags_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          fwft_mode,
  input logic          rflag_n,
  input logic          rd_en_n,
  input logic [AW:0]   wlevel,
  input logic [AW:0]   rlevel,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] dq
);
  localparam logic [AW:0] DEP = (AW+1)'(1 << AW);

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!mrst_n) wlevel <= DEP);
  p_no_underrun_r4: assert property (@(posedge rclk) disable iff (!mrst_n) rlevel <= DEP);
  p_wgray_step_r11: assert property (@(posedge wclk) disable iff (!mrst_n) $onehot0(wgray ^ $past(wgray)));
  p_rgray_step_r11: assert property (@(posedge rclk) disable iff (!mrst_n) $onehot0(rgray ^ $past(rgray)));
  p_empty_hold_r4: assert property (@(posedge rclk) disable iff (!mrst_n)
    (!fwft_mode && !rflag_n) |=> $stable(dq));
  p_ready_hold_r10: assert property (@(posedge rclk) disable iff (!mrst_n)
    (fwft_mode && !rflag_n && rd_en_n) |=> (!rflag_n && $stable(dq)));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.DW(DW), .AW(AW)) chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .fwft_mode(fwft_mode),
  .rflag_n(rflag_n), .rd_en_n(rd_en_n), .wlevel(wlevel), .rlevel(rlevel),
  .wgray(wgray), .rgray(rgray), .dq(dq)
);

// File: tb/dcfifo_flags_test.sv
`timescale 1ns/100ps
module dcfifo_flags_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0, mrst_n = 0, fwft = 0;
  logic [AW:0] empty_off = 2, full_off = 3;
  logic wr_en_n = 1, wr_cs_n = 0, rd_en_n = 1, rd_cs_n = 0, out_en_n = 0;
  logic [DW-1:0] din = 0;
  logic [DW-1:0] dout;
  logic dout_valid, rflag_n, wflag_n, ae_n, af_n, hf_n;

  dcfifo_flags #(.DW(DW), .AW(AW)) uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .fwft_mode(fwft),
    .empty_off(empty_off), .full_off(full_off),
    .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n), .din(din),
    .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .out_en_n(out_en_n),
    .dout(dout), .dout_valid(dout_valid), .rflag_n(rflag_n), .wflag_n(wflag_n),
    .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
  );

  initial forever #2 wclk = ~wclk;
  initial begin #0.3; forever #3 rclk = ~rclk; end

  int checks = 0, fails = 0;
  int wcnt = 0, rcnt = 0, w_mark = 0, r_mark = 0;
  logic [DW-1:0] q[$];
  bit done = 0;

  always @(posedge wclk) wcnt++;
  always @(posedge rclk) rcnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cap();
    return fwft ? DEPTH + 1 : DEPTH;
  endfunction

  task automatic wr(input logic [DW-1:0] d, input bit cs_n, output bit acc);
    @(negedge wclk);
    din = d; wr_cs_n = cs_n; wr_en_n = 0;
    acc = !cs_n && (fwft ? !wflag_n : wflag_n);
    if (acc) begin
      chk(q.size() < cap(), "R6 capacity", q.size(), cap() - 1);
      q.push_back(d);
    end
    @(posedge wclk);
    r_mark = rcnt;
    #1 wr_en_n = 1; wr_cs_n = 0;
  endtask

  task automatic rd(input bit cs_n, output bit acc);
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    prev = dout; exp = '0;
    rd_cs_n = cs_n; rd_en_n = 0;
    if (fwft) begin
      acc = !cs_n && !rflag_n;
      if (acc) begin
        chk(dout == q[0], "R10 ready word", dout, q[0]);
        void'(q.pop_front());
      end
    end else begin
      acc = !cs_n && rflag_n;
      if (acc) begin
        chk(q.size() > 0, "R4 read not past empty", q.size(), 1);
        exp = q.pop_front();
      end
    end
    @(posedge rclk);
    w_mark = wcnt;
    #1;
    if (cs_n) chk(dout_valid == 0, "R9 read chip select", dout_valid, 0);
    else if (!fwft && acc) chk(dout == exp, "R4 read data", dout, exp);
    else if (!fwft) chk(dout == prev, "R4 empty read ignored", dout, prev);
    rd_en_n = 1; rd_cs_n = 0;
  endtask

  task automatic settle();
    repeat (12) @(posedge wclk);
    #0.7;
  endtask

  task automatic do_reset(input bit mode);
    mrst_n = 0; fwft = mode; q.delete();
    wr_en_n = 1; rd_en_n = 1; wr_cs_n = 0; rd_cs_n = 0; out_en_n = 0;
    repeat (3) @(negedge wclk);
    #0.5;
    chk(rflag_n == mode, "R1 reset read flag", rflag_n, mode);
    chk(wflag_n == !mode, "R1 reset write flag", wflag_n, !mode);
    chk(ae_n == 0 && af_n == 1 && hf_n == 1, "R1 reset level flags",
        {ae_n, af_n, hf_n}, 3'b011);
    @(negedge wclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic wait_rflag(input logic target, output int lat);
    int g = 0;
    while (rflag_n != target && g < 20) begin @(posedge rclk); #0.2; g++; end
    lat = rcnt - r_mark;
  endtask

  task automatic stress(input int n);
    int got = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          bit a = 0;
          while (!a) begin
            repeat ($urandom_range(0, 2)) @(posedge wclk);
            wr(8'(i * 7 + 3), 0, a);
          end
        end
      end
      begin
        while (got < n) begin
          bit a;
          repeat ($urandom_range(0, 2)) @(posedge rclk);
          rd(0, a);
          if (a) got++;
        end
      end
    join
    chk(got == n && q.size() == 0, "R11 all words delivered", q.size(), 0);
  endtask

  always @(posedge rclk) begin
    #0.5;
    if (mrst_n && !fwft && rflag_n)
      chk(q.size() > 0, "R2 non-empty flag backed by data", q.size(), 1);
    if (mrst_n && fwft && !rflag_n && dout_valid && q.size() > 0)
      chk(dout == q[0], "R11 output word order", dout, q[0]);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit a;
    int lat;
    // standard mode
    do_reset(0);
    wr(8'h21, 0, a);
    wait_rflag(1, lat);
    chk(lat == 2 || lat == 3, "R2 empty clear latency", lat, 2);
    rd(0, a);
    chk(rflag_n == 0, "R4 empty at last read", rflag_n, 0);
    rd(0, a);
    chk(a == 0, "R4 read while empty", a, 0);
    wr(8'hEE, 1, a);
    settle();
    chk(rflag_n == 0, "R9 write chip select blocks", rflag_n, 0);
    wr(8'h55, 0, a);
    settle();
    rd(1, a);
    out_en_n = 1; #0.1;
    chk(dout_valid == 0, "R9 output enable", dout_valid, 0);
    out_en_n = 0;
    rd(0, a);
    chk(a == 1, "R9 word kept past deselected read", a, 1);
    settle();
    // threshold walk
    for (int i = 0; i < 2; i++) wr(8'(8'h10 + i), 0, a);
    settle();
    chk(ae_n == 0, "R7 almost empty at offset", ae_n, 0);
    wr(8'h12, 0, a);
    wait_rflag(1, lat);
    begin
      int g = 0;
      while (ae_n != 1 && g < 20) begin @(posedge rclk); #0.2; g++; end
      lat = rcnt - r_mark;
    end
    chk(lat == 2 || lat == 3, "R7 almost empty clear latency", lat, 2);
    for (int i = 3; i < 8; i++) wr(8'(8'h10 + i), 0, a);
    settle();
    chk(hf_n == 1 && af_n == 1, "R8 level 8 flags", {hf_n, af_n}, 2'b11);
    wr(8'h18, 0, a);
    settle();
    chk(hf_n == 0, "R8 half full past half", hf_n, 0);
    for (int i = 9; i < 12; i++) wr(8'(8'h10 + i), 0, a);
    settle();
    chk(af_n == 1, "R8 almost full below threshold", af_n, 1);
    wr(8'h1C, 0, a);
    settle();
    chk(af_n == 0, "R8 almost full at threshold", af_n, 0);
    for (int i = 13; i < 16; i++) wr(8'(8'h10 + i), 0, a);
    settle();
    chk(wflag_n == 0, "R3 full at depth", wflag_n, 0);
    for (int i = 0; i < 3; i++) wr(8'hAA, 0, a);
    settle();
    rd(0, a);
    begin
      int g = 0;
      while (wflag_n != 1 && g < 20) begin @(posedge wclk); #0.2; g++; end
      lat = wcnt - w_mark;
    end
    chk(lat == 2 || lat == 3, "R3 full clear latency", lat, 2);
    while (q.size() > 0) rd(0, a);
    chk(rflag_n == 0, "R4 empty after drain", rflag_n, 0);
    settle();
    chk(rflag_n == 0, "R3 writes while full dropped", rflag_n, 0);
    stress(300);

    // fall-through mode
    do_reset(1);
    wr(8'h3C, 0, a);
    wait_rflag(0, lat);
    chk(lat == 3 || lat == 4, "R5 ready latency", lat, 3);
    #0.5;
    chk(dout == 8'h3C && dout_valid, "R5 first word falls through", dout, 8'h3C);
    settle();
    chk(dout == 8'h3C && rflag_n == 0, "R10 word held without read", dout, 8'h3C);
    for (int i = 0; i < 20; i++) wr(8'(8'h40 + i), 0, a);
    settle();
    chk(q.size() == DEPTH + 1, "R6 depth plus one stored", q.size(), DEPTH + 1);
    chk(wflag_n == 1, "R6 no room flag", wflag_n, 1);
    while (q.size() > 0) rd(0, a);
    chk(rflag_n == 1, "R10 not ready after last read", rflag_n, 1);
    settle();
    stress(300);
    finish_run();
  end
endmodule